// File: doc/BRIEF.md
# Boundary-Scan Pad Wrapper Chain

This block sits between the peripheral-side signals of the core and the pad-side signals of a small group of pins. A parameter gives each pin one of four kinds: input-only, output-only, tristate output or bidirectional. Every kind uses the same three-wire pad connection of input, output and output-enable. The block puts scan cells only on the wires that the pin's kind actually uses. Each tapped wire gets two cells: one faces the core and one faces the pad. In test mode the pad and the peripheral can therefore be driven and observed independently.

With `scan_en` low, every mux is transparent. Core output and enable go to the pad, and the pad level goes to the core. With `scan_en` high, the pad's output and enable and the core's input are driven from update latches. Observe cells take a snapshot of the live core output, core enable and pad input on the capture strobe. An external test-access controller supplies the `capture`, `shift` and `update` strobes and the serial data. The chain always accepts a bit, so there is no back-pressure: `shift` alone qualifies each bit, and one bit moves per clock while it is high.

Top module: `bscan_pad_chain`

## Requirements
- R1: Kind code per pin (2 bits at [2p+1:2p] of `PIN_KINDS`): 0 = input, 1 = output, 2 = tristate, 3 = bidirectional. The cells per pin are: input 2, output 2, tristate 4, bidirectional 6. The chain length is the sum of these, which is 14 for the default kinds {3,2,1,0}.
- R2: With `scan_en` low, `pad_out` = `core_out` and `pad_oe` = `core_oe` on pins that have an enable, and `core_in` = `pad_in` on pins that have an input. These paths are combinational.
- R3: Wires a kind does not use are tied off in both modes. Output and tristate pins read `core_in` = 0. Input pins drive `pad_out` = 0 and `pad_oe` = 0. Output-only pins drive `pad_oe` = 1.
- R4: With `scan_en` high, `pad_out`, `pad_oe` and `core_in` come only from their update latches. Changes on `core_out`, `core_oe` and `pad_in` have no effect on them.
- R5: On a `capture` edge, observe cells load the live `core_out`, `core_oe` and `pad_in` of their pin. Drive cells reload their shift stage from their own update latch.
- R6: Chain position order: pins by ascending index, nearest `tdi` first. Within a pin the order is core-out observe, core-enable observe, pad-in observe, pad-out drive, pad-enable drive, core-in drive, and absent cells are skipped. With the defaults, the drive positions are 1 (pin0 core-in), 3 (pin1 pad-out), 6/7 (pin2 pad-out/enable) and 11/12/13 (pin3 pad-out/enable/core-in).
- R7: While `shift` is high and `capture` is low, each clock moves the chain one position: `tdi` enters position 0, and `tdo` shows the last position as a registered value.
- R8: When `capture` and `shift` are high in the same cycle, the capture takes effect and the shift is ignored.
- R9: An `update` edge copies each drive cell's shift stage, as it stood before that edge, into its latch. This also holds when `shift` is high in the same cycle. Without `update`, test-mode outputs do not change, including while shifting.
- R10: Reset (`rst_n` low, asynchronous) clears every shift stage and update latch. Entering test mode after reset therefore gives `pad_out` = 0, `pad_oe` = 0 except on output-only pins, and `core_in` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_en | input | 1 | Test mode select |
| capture | input | 1 | Load observe points into the chain |
| shift | input | 1 | Advance the chain one bit |
| update | input | 1 | Copy drive-cell shift stages into latches |
| tdi | input | 1 | Serial data into chain position 0 |
| tdo | output | 1 | Serial data from the last chain position |
| core_out | input | NPINS | Peripheral output per pin |
| core_oe | input | NPINS | Peripheral output-enable per pin |
| core_in | output | NPINS | Level delivered to the peripheral |
| pad_in | input | NPINS | Level sensed at the pad |
| pad_out | output | NPINS | Value driven to the pad |
| pad_oe | output | NPINS | Pad driver enable |

## Verification
Two pairs of strobes can meet on one clock edge, and the bench provokes both. The first pair is update with shift. The bench shifts in a known word, then raises `shift` and `update` together. It expects the pad outputs to show the pre-shift word, and after a lone update it expects the word moved by one position with the new `tdi` bit at position 0. The second pair is capture with shift. The bench raises both strobes and then reads the whole chain out serially, expecting the captured snapshot bit for bit with nothing displaced.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

  typedef enum logic [1:0] {
    KIND_IN    = 2'd0,
    KIND_OUT   = 2'd1,
    KIND_TRI   = 2'd2,
    KIND_BIDIR = 2'd3
  } pad_kind_e;

  localparam int SEL_OUT   = 0;
  localparam int SEL_OE    = 1;
  localparam int SEL_IN    = 2;
  localparam int SEL_FIXOE = 3;

  function automatic bit kind_has_in(logic [1:0] k);
    return (k == KIND_IN) || (k == KIND_BIDIR);
  endfunction

  function automatic bit kind_has_out(logic [1:0] k);
    return (k != KIND_IN);
  endfunction

  function automatic bit kind_has_oe(logic [1:0] k);
    return (k == KIND_TRI) || (k == KIND_BIDIR);
  endfunction

  // One bit per pin telling whether the selected wire exists for that pin.
  function automatic logic [63:0] wire_mask(int n, logic [127:0] kinds, int sel);
    logic [63:0] m;
    logic [1:0]  k;
    m = '0;
    for (int i = 0; i < 64; i++) begin
      if (i < n) begin
        k = kinds[2*i +: 2];
        case (sel)
          SEL_OUT: m[i] = kind_has_out(k);
          SEL_OE:  m[i] = kind_has_oe(k);
          SEL_IN:  m[i] = kind_has_in(k);
          default: m[i] = (k == KIND_OUT);
        endcase
      end
    end
    return m;
  endfunction

endpackage

// File: rtl/bscan_obs_cell.sv
module bscan_obs_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic capture,
  input  logic shift,
  input  logic sin,
  input  logic obs,
  output logic sq
);
  // Observe point: snapshot of a live wire, or one stage of the chain.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sq <= 1'b0;
    else if (capture) sq <= obs;
    else if (shift)   sq <= sin;
  end
endmodule

// File: rtl/bscan_drv_cell.sv
module bscan_drv_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic capture,
  input  logic shift,
  input  logic update,
  input  logic sin,
  output logic sq,
  output logic uq
);
  // Drive point: the shift stage plus an update latch that holds the muxed value.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sq <= 1'b0;
    else if (capture) sq <= uq;
    else if (shift)   sq <= sin;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      uq <= 1'b0;
    else if (update) uq <= sq;
  end
endmodule

// File: rtl/bscan_pad_chain.sv
module bscan_pad_chain #(
  parameter int                    NPINS     = 4,
  parameter logic [2*NPINS-1:0]    PIN_KINDS = 8'b11_10_01_00
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scan_en,
  input  logic             capture,
  input  logic             shift,
  input  logic             update,
  input  logic             tdi,
  output logic             tdo,
  input  logic [NPINS-1:0] core_out,
  input  logic [NPINS-1:0] core_oe,
  output logic [NPINS-1:0] core_in,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe
);
  import bscan_pkg::*;

  localparam logic [NPINS-1:0] OUT_M = NPINS'(wire_mask(NPINS, 128'(PIN_KINDS), SEL_OUT));
  localparam logic [NPINS-1:0] OE_M  = NPINS'(wire_mask(NPINS, 128'(PIN_KINDS), SEL_OE));
  localparam logic [NPINS-1:0] IN_M  = NPINS'(wire_mask(NPINS, 128'(PIN_KINDS), SEL_IN));
  localparam logic [NPINS-1:0] FIX_M = NPINS'(wire_mask(NPINS, 128'(PIN_KINDS), SEL_FIXOE));

  logic [NPINS:0]   link;
  logic [NPINS-1:0] upd_pout, upd_poe, upd_cin;

  assign link[0] = tdi;
  assign tdo     = link[NPINS];

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    localparam logic [1:0] K   = PIN_KINDS[2*p +: 2];
    localparam bit         HO  = kind_has_out(K);
    localparam bit         HOE = kind_has_oe(K);
    localparam bit         HI  = kind_has_in(K);

    // lk[s] feeds slot s; lk[s+1] is its output (or a bypass when the slot is absent).
    logic [6:0] lk;
    assign lk[0]     = link[p];
    assign link[p+1] = lk[6];

    if (HO) begin : g_cout
      bscan_obs_cell u_cell (.clk(clk), .rst_n(rst_n), .capture(capture), .shift(shift),
                             .sin(lk[0]), .obs(core_out[p]), .sq(lk[1]));
    end else begin : g_cout_skip
      assign lk[1] = lk[0];
    end

    if (HOE) begin : g_coe
      bscan_obs_cell u_cell (.clk(clk), .rst_n(rst_n), .capture(capture), .shift(shift),
                             .sin(lk[1]), .obs(core_oe[p]), .sq(lk[2]));
    end else begin : g_coe_skip
      assign lk[2] = lk[1];
    end

    if (HI) begin : g_pin_in
      bscan_obs_cell u_cell (.clk(clk), .rst_n(rst_n), .capture(capture), .shift(shift),
                             .sin(lk[2]), .obs(pad_in[p]), .sq(lk[3]));
    end else begin : g_pin_in_skip
      assign lk[3] = lk[2];
    end

    if (HO) begin : g_pout
      bscan_drv_cell u_cell (.clk(clk), .rst_n(rst_n), .capture(capture), .shift(shift),
                             .update(update), .sin(lk[3]), .sq(lk[4]), .uq(upd_pout[p]));
    end else begin : g_pout_skip
      assign lk[4]       = lk[3];
      assign upd_pout[p] = 1'b0;
    end

    if (HOE) begin : g_poe
      bscan_drv_cell u_cell (.clk(clk), .rst_n(rst_n), .capture(capture), .shift(shift),
                             .update(update), .sin(lk[4]), .sq(lk[5]), .uq(upd_poe[p]));
    end else begin : g_poe_skip
      assign lk[5]      = lk[4];
      assign upd_poe[p] = HO;  // output-only pads stay enabled, input pads stay off
    end

    if (HI) begin : g_cin
      bscan_drv_cell u_cell (.clk(clk), .rst_n(rst_n), .capture(capture), .shift(shift),
                             .update(update), .sin(lk[5]), .sq(lk[6]), .uq(upd_cin[p]));
    end else begin : g_cin_skip
      assign lk[6]      = lk[5];
      assign upd_cin[p] = 1'b0;
    end
  end

  // Pad-side and core-side muxes, one pair per tapped wire.
  always_comb begin
    if (scan_en) begin
      pad_out = upd_pout;
      pad_oe  = upd_poe;
      core_in = upd_cin;
    end else begin
      pad_out = core_out & OUT_M;
      pad_oe  = (core_oe & OE_M) | FIX_M;
      core_in = pad_in & IN_M;
    end
  end

endmodule

// File: rtl/bscan_pad_chain_chk.sv
module bscan_pad_chain_chk #(
  parameter int                 NPINS     = 4,
  parameter logic [2*NPINS-1:0] PIN_KINDS = 8'b11_10_01_00
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scan_en,
  input logic             capture,
  input logic             shift,
  input logic             update,
  input logic             tdo,
  input logic [NPINS-1:0] core_out,
  input logic [NPINS-1:0] core_oe,
  input logic [NPINS-1:0] core_in,
  input logic [NPINS-1:0] pad_in,
  input logic [NPINS-1:0] pad_out,
  input logic [NPINS-1:0] pad_oe
);
  import bscan_pkg::*;

  localparam logic [NPINS-1:0] OUT_M = NPINS'(wire_mask(NPINS, 128'(PIN_KINDS), SEL_OUT));
  localparam logic [NPINS-1:0] OE_M  = NPINS'(wire_mask(NPINS, 128'(PIN_KINDS), SEL_OE));
  localparam logic [NPINS-1:0] IN_M  = NPINS'(wire_mask(NPINS, 128'(PIN_KINDS), SEL_IN));
  localparam logic [NPINS-1:0] FIX_M = NPINS'(wire_mask(NPINS, 128'(PIN_KINDS), SEL_FIXOE));

  // R2
  bypass_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en |-> (pad_out == (core_out & OUT_M)) && (core_in == (pad_in & IN_M)) &&
                 (pad_oe == ((core_oe & OE_M) | FIX_M)));

  // R3
  unused_wire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_out & ~OUT_M) == '0) && ((core_in & ~IN_M) == '0) &&
    ((pad_oe & FIX_M) == FIX_M) && ((pad_oe & ~(OE_M | FIX_M)) == '0));

  // R9
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_en && $past(scan_en) && !$past(update)) |->
      ($stable(pad_out) && $stable(pad_oe) && $stable(core_in)));

  // R7
  tdo_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift && !capture) |=> $stable(tdo));

endmodule

bind bscan_pad_chain bscan_pad_chain_chk #(.NPINS(NPINS), .PIN_KINDS(PIN_KINDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .capture(capture), .shift(shift),
  .update(update), .tdo(tdo), .core_out(core_out), .core_oe(core_oe), .core_in(core_in),
  .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
);

// File: tb/bscan_pad_chain_tb.sv
module bscan_pad_chain_tb;
  localparam int NP = 4;
  localparam logic [13:0] DRV = 14'b11100011001010;  // R6: drive positions 1,3,6,7,11,12,13

  logic clk = 1'b0, rst_n = 1'b0;
  logic scan_en = 1'b0, capture = 1'b0, shift = 1'b0, update = 1'b0, tdi = 1'b0;
  logic tdo;
  logic [NP-1:0] core_out = '0, core_oe = '0, pad_in = '0;
  logic [NP-1:0] core_in, pad_out, pad_oe;

  always #4 clk = ~clk;

  bscan_pad_chain u_dut (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .capture(capture), .shift(shift),
    .update(update), .tdi(tdi), .tdo(tdo), .core_out(core_out), .core_oe(core_oe),
    .core_in(core_in), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  typedef struct { logic [31:0] exp; string tag; } sb_item_t;
  sb_item_t    sb_q[$];
  logic [31:0] act_v;
  event        smp_ev;
  int          n_vec = 0, n_bad = 0;

  // Monitor: pops the next expected item whenever a result is presented.
  initial forever begin
    sb_item_t it;
    @(smp_ev);
    n_vec++;
    if (sb_q.size() == 0) begin
      n_bad++;
      $display("FAIL scoreboard empty act=%h exp=none", act_v);
    end else begin
      it = sb_q.pop_front();
      if (act_v !== it.exp) begin
        n_bad++;
        $display("FAIL %s act=%h exp=%h", it.tag, act_v, it.exp);
      end
    end
  end

  task automatic chk(logic [31:0] a, logic [31:0] e, string tag);
    sb_q.push_back('{e, tag});
    act_v = a;
    ->smp_ev;
    #1;
  endtask

  function automatic logic [31:0] outs();
    return {20'd0, pad_out, pad_oe, core_in};
  endfunction

  function automatic logic [31:0] exp_norm(logic [3:0] co, logic [3:0] coe, logic [3:0] pi);
    return {20'd0, co & 4'b1110, (coe & 4'b1100) | 4'b0010, pi & 4'b1001};
  endfunction

  function automatic logic [31:0] exp_test(logic [13:0] u);
    return {20'd0, u[11], u[6], u[3], 1'b0, u[12], u[7], 1'b1, 1'b0, u[13], 1'b0, 1'b0, u[1]};
  endfunction

  function automatic logic [13:0] exp_cap(logic [3:0] co, logic [3:0] coe, logic [3:0] pi,
                                          logic [13:0] u);
    logic [13:0] v;
    v = u & DRV;
    v[0] = pi[0]; v[2] = co[1]; v[4] = co[2]; v[5] = coe[2];
    v[8] = co[3]; v[9] = coe[3]; v[10] = pi[3];
    return v;
  endfunction

  task automatic set_io(logic [3:0] co, logic [3:0] coe, logic [3:0] pi);
    @(negedge clk);
    core_out = co; core_oe = coe; pad_in = pi;
    #1;
  endtask

  // Highest position goes in first; mid-way the outputs must still show 'hold'.
  task automatic shift_in(logic [13:0] v, logic [13:0] hold);
    for (int i = 13; i >= 0; i--) begin
      @(negedge clk);
      if (i == 6) chk(outs(), exp_test(hold), "R9 outputs held while shifting");
      tdi = v[i]; shift = 1'b1;
    end
    @(negedge clk);
    shift = 1'b0;
    #1;
  endtask

  task automatic read_chain(logic [13:0] e, string tag);
    shift = 1'b1; tdi = 1'b0;
    for (int k = 13; k >= 0; k--) begin
      chk({31'd0, tdo}, {31'd0, e[k]}, tag);
      @(negedge clk);
    end
    shift = 1'b0;
    #1;
  endtask

  task automatic capture_read(logic [13:0] e, string tag);
    @(negedge clk);
    capture = 1'b1; shift = 1'b1; tdi = 1'b1;   // R8: shift in the same cycle must lose
    @(negedge clk);
    capture = 1'b0;
    read_chain(e, tag);
  endtask

  task automatic pulse_update();
    @(negedge clk); update = 1'b1;
    @(negedge clk); update = 1'b0;
    #1;
  endtask

  task automatic report();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog act=running exp=done");
    report();
  end

  initial begin
    logic [13:0] v1, v2, v3, v4;
    v1 = 14'h3FFF; v2 = 14'h25AC; v3 = 14'h2C71; v4 = 14'h1B4E;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R10 reset state
    chk({31'd0, tdo}, 32'd0, "R10 tdo after reset");
    chk(outs(), exp_norm(4'h0, 4'h0, 4'h0), "R10 normal outputs after reset");
    scan_en = 1'b1; #1;
    chk(outs(), exp_test(14'h0), "R10/R3 test outputs on entry");
    scan_en = 1'b0;

    // R2/R3 bypass under several patterns
    set_io(4'hF, 4'hF, 4'hF); chk(outs(), exp_norm(4'hF, 4'hF, 4'hF), "R2 bypass all ones");
    set_io(4'hA, 4'h5, 4'h6); chk(outs(), exp_norm(4'hA, 4'h5, 4'h6), "R2 bypass pattern A");
    set_io(4'h5, 4'hA, 4'h9); chk(outs(), exp_norm(4'h5, 4'hA, 4'h9), "R3 bypass pattern B");
    set_io(4'h3, 4'hC, 4'hE); chk(outs(), exp_norm(4'h3, 4'hC, 4'hE), "R2 bypass pattern C");

    // R5/R6/R8 capture snapshot read out serially
    scan_en = 1'b1;
    set_io(4'hE, 4'hC, 4'h9);
    capture_read(exp_cap(4'hE, 4'hC, 4'h9, 14'h0), "R5 R6 R8 capture snapshot");

    // R7/R9 load, update, hold while shifting
    shift_in(v1, 14'h0);
    pulse_update(); chk(outs(), exp_test(v1), "R9 update word 1");
    shift_in(v2, v1);
    pulse_update(); chk(outs(), exp_test(v2), "R9 update word 2");

    // R4 isolation from live wires in test mode
    set_io(4'hF, 4'hF, 4'hF); chk(outs(), exp_test(v2), "R4 live ones ignored");
    set_io(4'h0, 4'h0, 4'h0); chk(outs(), exp_test(v2), "R4 live zeros ignored");

    // R5 drive cells capture their latch contents
    set_io(4'h6, 4'h4, 4'h1);
    capture_read(exp_cap(4'h6, 4'h4, 4'h1, v2), "R5 capture with loaded latches");

    // R7 plain shift through the whole chain
    shift_in(v3, v2);
    read_chain(v3, "R7 serial pass-through");

    // R9 update and shift in one cycle
    shift_in(v4, v2);
    @(negedge clk); shift = 1'b1; update = 1'b1; tdi = 1'b1;
    @(negedge clk); shift = 1'b0; update = 1'b0; #1;
    chk(outs(), exp_test(v4), "R9 update beside shift takes pre-shift word");
    pulse_update();
    chk(outs(), exp_test({v4[12:0], 1'b1}), "R9 later update sees shifted word");

    // R1/R2 back to normal mode
    scan_en = 1'b0;
    set_io(4'hB, 4'h7, 4'hD); chk(outs(), exp_norm(4'hB, 4'h7, 4'hD), "R1 R2 bypass after test");

    report();
  end
endmodule